// File: doc/BRIEF.md
# Page write sequencer

This block receives the data bytes of one array write command from a serial front end. It gathers them into a buffer that holds one page, then runs the timed program cycle that commits them to a register-array model of the memory. The command opens with a start pulse that carries the first address and the state of the write-enable latch. Data bytes follow one per pulse. A deselect pulse closes the command and reports whether the bus stopped exactly on a byte boundary. A per-byte protection flag comes from the policy logic, which lies outside this block.

The first byte may land on any offset within its page. Later bytes take the following offsets and wrap inside the same page, so a long burst overwrites bytes it sent earlier. A program cycle starts only when all of these hold: the command was enabled, at least one byte arrived, and the deselect fell on a byte boundary. The cycle lasts a fixed number of system clocks. For that whole time the busy flag is high and the array accepts no reads and no new commands. At the end, a one-clock done pulse tells the surrounding logic to clear its write-enable latch.

Top module: `page_write_seq`

## Requirements
- R1: After reset `wip_o` and `wr_done_o` are 0, and every array byte reads FFh.
- R2: The first data byte goes to the offset given by the low log2(PAGE_BYTES) bits of `addr_i`. Each later byte goes to the next offset. All bytes are written into the page selected by the upper address bits.
- R3: After offset PAGE_BYTES-1 the next byte goes to offset 0 of the same page. The later byte replaces the earlier one at that offset.
- R4: A deselect with `byte_aligned_i`=0 cancels the command. No program cycle starts and the array is unchanged.
- R5: A command whose `wel_i` was 0 on its start pulse is ignored. No cycle starts and the array is unchanged.
- R6: A byte received with `prot_hit_i`=1 is not programmed, and its location keeps its old value. The other bytes of the same command are still programmed.
- R7: An accepted deselect raises `wip_o` on the next clock. `wip_o` stays high for exactly PROG_CYCLES clocks. In the first clock after it falls, `wr_done_o` is high for one clock and the new contents can be read.
- R8: While `wip_o` is high, start pulses, bytes, deselects and reads are all ignored (`rd_valid_o` stays 0), and the cycle ends on time.
- R9: Only offsets received in the current command are programmed, because a start pulse clears the valid mask. Bytes that arrive outside a command are ignored.
- R10: When idle, `rd_en_i` returns `rd_valid_o`=1 and the byte at `rd_addr_i` one clock later.
- R11: A deselect before any data byte starts no program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start_i | input | 1 | Pulse: a write command begins |
| addr_i | input | log2(MEM_BYTES) | Start address, taken with `cmd_start_i` |
| wel_i | input | 1 | Write-enable latch state, taken with `cmd_start_i` |
| byte_valid_i | input | 1 | Pulse: one data byte received |
| byte_i | input | 8 | Received data byte |
| prot_hit_i | input | 1 | The current byte's address is protected |
| desel_i | input | 1 | Pulse: chip select rose |
| byte_aligned_i | input | 1 | The bit count was a multiple of 8 when `desel_i` pulsed |
| rd_en_i | input | 1 | Array read request |
| rd_addr_i | input | log2(MEM_BYTES) | Array read address |
| rd_data_o | output | 8 | Read data |
| rd_valid_o | output | 1 | Read data is valid |
| wip_o | output | 1 | Program cycle in progress |
| wr_done_o | output | 1 | One-clock pulse when the program cycle completes |

## Verification
The bench builds the block with MEM_BYTES=128 (four pages), PAGE_BYTES=32 and PROG_CYCLES=24. With only four pages, every page can be read back in full after every command. The bench sweeps all 32 start offsets, with burst lengths from 1 to 45, so each run checks whether it should wrap and overwrite. A program time of 24 clocks is long enough to inject a full second command and a read inside one cycle. It is also short enough to count each cycle clock by clock.

// File: rtl/pws_pkg.sv
package pws_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COLLECT = 2'd1,
      ST_PROG    = 2'd2
   } pws_state_e;

endpackage

// File: rtl/pws_timer.sv
module pws_timer #(
   parameter int unsigned CYCLES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic fire_o
);

   localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   logic busy_q;

   generate
      if (CYCLES == 0) begin : g_bad_cycles
         $error("pws_timer: CYCLES must be at least 1");
      end

      if (CYCLES == 1) begin : g_single
         assign fire_o = busy_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (start_i && !busy_q) begin
               cnt_q <= CNT_W'(CYCLES - 1);
            end else if (busy_q && (cnt_q != '0)) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign fire_o = busy_q && (cnt_q == '0);

         // R7: the remaining count never exceeds the programmed length
         assert_cnt_range_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            busy_q |-> (cnt_q <= CNT_W'(CYCLES - 1)));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
      end else if (fire_o) begin
         busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;

endmodule

// File: rtl/pws_page_buf.sv
module pws_page_buf #(
   parameter int unsigned PAGE_BYTES = 32,
   parameter int unsigned OFS_W      = $clog2(PAGE_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic [OFS_W-1:0]        ofs_i,
   input  logic                    wr_i,
   input  logic [7:0]              byte_i,
   input  logic                    prot_i,
   output logic [PAGE_BYTES*8-1:0] data_o,
   output logic [PAGE_BYTES-1:0]   mask_o
);

   logic [OFS_W-1:0] ptr_q;

   // Pointer wraps naturally at the page size (power of two)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (clr_i) begin
         ptr_q <= ofs_i;
      end else if (wr_i) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   generate
      for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
         logic [7:0] d_q;
         logic       m_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q <= '0;
               m_q <= 1'b0;
            end else if (clr_i) begin
               m_q <= 1'b0;
            end else if (wr_i && (ptr_q == OFS_W'(s))) begin
               d_q <= byte_i;
               m_q <= !prot_i;
            end
         end

         assign data_o[s*8 +: 8] = d_q;
         assign mask_o[s]        = m_q;
      end
   endgenerate

   // R9: a start clears every valid bit
   assert_mask_cleared_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (mask_o == '0));

   // R6: an unprotected byte marks its slot for programming
   assert_slot_marked_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clr_i && !prot_i) |=> mask_o[$past(ptr_q)]);

   // R3: writing at the last offset leaves the pointer at offset 0
   assert_ptr_wrap_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clr_i && (ptr_q == OFS_W'(PAGE_BYTES - 1))) |=> (ptr_q == '0));

endmodule

// File: rtl/pws_array.sv
module pws_array #(
   parameter int unsigned MEM_BYTES  = 1024,
   parameter int unsigned PAGE_BYTES = 32,
   parameter int unsigned ADDR_W     = $clog2(MEM_BYTES),
   parameter int unsigned OFS_W      = $clog2(PAGE_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en_i,
   input  logic [ADDR_W-OFS_W-1:0] wr_page_i,
   input  logic [PAGE_BYTES*8-1:0] wr_data_i,
   input  logic [PAGE_BYTES-1:0]   wr_mask_i,
   input  logic                    busy_i,
   input  logic                    rd_en_i,
   input  logic [ADDR_W-1:0]       rd_addr_i,
   output logic [7:0]              rd_data_o,
   output logic                    rd_valid_o
);

   logic [7:0] mem_q [MEM_BYTES];
   logic [7:0] rd_data_q;
   logic       rd_valid_q;

   // Erased state is all ones; a commit writes only the masked slots
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(MEM_BYTES); i++) begin
            mem_q[i] <= 8'hFF;
         end
      end else if (wr_en_i) begin
         for (int p = 0; p < int'(PAGE_BYTES); p++) begin
            if (wr_mask_i[p]) begin
               mem_q[{wr_page_i, OFS_W'(p)}] <= wr_data_i[p*8 +: 8];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= rd_en_i && !busy_i;
         if (rd_en_i && !busy_i) begin
            rd_data_q <= mem_q[rd_addr_i];
         end
      end
   end

   assign rd_data_o  = rd_data_q;
   assign rd_valid_o = rd_valid_q;

   // R8: no read completes out of a busy cycle
   assert_rd_blocked_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> !$past(busy_i));

endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
   import pws_pkg::*;
#(
   parameter int unsigned MEM_BYTES   = 1024,
   parameter int unsigned PAGE_BYTES  = 32,
   parameter int unsigned PROG_CYCLES = 500000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_start_i,
   input  logic [$clog2(MEM_BYTES)-1:0] addr_i,
   input  logic                         wel_i,
   input  logic                         byte_valid_i,
   input  logic [7:0]                   byte_i,
   input  logic                         prot_hit_i,
   input  logic                         desel_i,
   input  logic                         byte_aligned_i,
   input  logic                         rd_en_i,
   input  logic [$clog2(MEM_BYTES)-1:0] rd_addr_i,
   output logic [7:0]                   rd_data_o,
   output logic                         rd_valid_o,
   output logic                         wip_o,
   output logic                         wr_done_o
);

   localparam int unsigned ADDR_W = $clog2(MEM_BYTES);
   localparam int unsigned OFS_W  = $clog2(PAGE_BYTES);
   localparam int unsigned PG_W   = ADDR_W - OFS_W;

   generate
      if ((PAGE_BYTES < 2) || ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0)) begin : g_bad_page
         $error("page_write_seq: PAGE_BYTES must be a power of two, at least 2");
      end
      if ((MEM_BYTES <= PAGE_BYTES) || ((MEM_BYTES & (MEM_BYTES - 1)) != 0)) begin : g_bad_mem
         $error("page_write_seq: MEM_BYTES must be a power of two above PAGE_BYTES");
      end
      if (PROG_CYCLES < 1) begin : g_bad_prog
         $error("page_write_seq: PROG_CYCLES must be at least 1");
      end
   endgenerate

   pws_state_e state_q;
   logic                    got_any_q;
   logic [PG_W-1:0]         page_q;
   logic                    wr_done_q;
   logic                    busy;
   logic                    fire;
   logic [PAGE_BYTES*8-1:0] buf_data;
   logic [PAGE_BYTES-1:0]   buf_mask;

   logic can_cmd;
   logic take_byte;
   logic launch;

   assign can_cmd   = cmd_start_i && (state_q != ST_PROG);
   assign take_byte = byte_valid_i && (state_q == ST_COLLECT) && !cmd_start_i && !desel_i;
   assign launch    = desel_i && (state_q == ST_COLLECT) && !cmd_start_i
                      && byte_aligned_i && got_any_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         got_any_q <= 1'b0;
         page_q    <= '0;
         wr_done_q <= 1'b0;
      end else begin
         wr_done_q <= fire;
         unique case (state_q)
            ST_PROG: begin
               if (fire) begin
                  state_q <= ST_IDLE;
               end
            end
            default: begin
               if (can_cmd) begin
                  state_q   <= wel_i ? ST_COLLECT : ST_IDLE;
                  got_any_q <= 1'b0;
                  page_q    <= addr_i[ADDR_W-1:OFS_W];
               end else if (desel_i && (state_q == ST_COLLECT)) begin
                  state_q <= launch ? ST_PROG : ST_IDLE;
               end else if (take_byte) begin
                  got_any_q <= 1'b1;
               end
            end
         endcase
      end
   end

   pws_page_buf #(
      .PAGE_BYTES (PAGE_BYTES),
      .OFS_W      (OFS_W)
   ) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (can_cmd && wel_i),
      .ofs_i  (addr_i[OFS_W-1:0]),
      .wr_i   (take_byte),
      .byte_i (byte_i),
      .prot_i (prot_hit_i),
      .data_o (buf_data),
      .mask_o (buf_mask)
   );

   pws_timer #(
      .CYCLES (PROG_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (launch),
      .busy_o  (busy),
      .fire_o  (fire)
   );

   pws_array #(
      .MEM_BYTES  (MEM_BYTES),
      .PAGE_BYTES (PAGE_BYTES),
      .ADDR_W     (ADDR_W),
      .OFS_W      (OFS_W)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (fire),
      .wr_page_i  (page_q),
      .wr_data_i  (buf_data),
      .wr_mask_i  (buf_mask),
      .busy_i     (busy),
      .rd_en_i    (rd_en_i),
      .rd_addr_i  (rd_addr_i),
      .rd_data_o  (rd_data_o),
      .rd_valid_o (rd_valid_o)
   );

   assign wip_o     = busy;
   assign wr_done_o = wr_done_q;

   // R4: the busy flag only rises after an aligned deselect that closes a command
   assert_launch_aligned_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip_o) |-> $past(desel_i && byte_aligned_i && (state_q == ST_COLLECT)));

   // R7: the done pulse marks the clock right after the busy flag drops
   assert_done_after_busy_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_done_o |-> (!wip_o && $past(wip_o)));

   // R8: the sequencer stays in its program state only while the timer runs
   assert_prog_busy_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PROG) |-> wip_o);

   // R5: a disabled start never opens a collecting command
   assert_wel_gate_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start_i && !wel_i && (state_q != ST_PROG)) |=> (state_q == ST_IDLE));

endmodule

// File: tb/test_page_write_seq.sv
module test_page_write_seq;

   localparam int unsigned MEM  = 128;
   localparam int unsigned PAGE = 32;
   localparam int unsigned PROG = 24;
   localparam int unsigned AW   = $clog2(MEM);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_start_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          wel_i = 1'b0;
   logic          byte_valid_i = 1'b0;
   logic [7:0]    byte_i = '0;
   logic          prot_hit_i = 1'b0;
   logic          desel_i = 1'b0;
   logic          byte_aligned_i = 1'b0;
   logic          rd_en_i = 1'b0;
   logic [AW-1:0] rd_addr_i = '0;
   logic [7:0]    rd_data_o;
   logic          rd_valid_o;
   logic          wip_o;
   logic          wr_done_o;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;
   logic [7:0] mdl [MEM];

   always #2 clk = ~clk;

   page_write_seq #(
      .MEM_BYTES   (MEM),
      .PAGE_BYTES  (PAGE),
      .PROG_CYCLES (PROG)
   ) i_page_write_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_start_i    (cmd_start_i),
      .addr_i         (addr_i),
      .wel_i          (wel_i),
      .byte_valid_i   (byte_valid_i),
      .byte_i         (byte_i),
      .prot_hit_i     (prot_hit_i),
      .desel_i        (desel_i),
      .byte_aligned_i (byte_aligned_i),
      .rd_en_i        (rd_en_i),
      .rd_addr_i      (rd_addr_i),
      .rd_data_o      (rd_data_o),
      .rd_valid_o     (rd_valid_o),
      .wip_o          (wip_o),
      .wr_done_o      (wr_done_o)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic send_cmd(int addr, bit wel);
      cmd_start_i = 1'b1;
      addr_i      = AW'(addr);
      wel_i       = wel;
      @(negedge clk);
      cmd_start_i = 1'b0;
   endtask

   task automatic send_byte(logic [7:0] d, bit p);
      byte_valid_i = 1'b1;
      byte_i       = d;
      prot_hit_i   = p;
      @(negedge clk);
      byte_valid_i = 1'b0;
      prot_hit_i   = 1'b0;
   endtask

   task automatic send_desel(bit al);
      desel_i        = 1'b1;
      byte_aligned_i = al;
      @(negedge clk);
      desel_i        = 1'b0;
      byte_aligned_i = 1'b0;
   endtask

   task automatic wait_prog(string req, bit run);
      int n;
      if (run) begin
         chk(req, "wip after deselect", int'(wip_o), 1);
         n = 1;
         while (wip_o) begin
            @(negedge clk);
            if (wip_o) n++;
         end
         chk(req, "program length", n, int'(PROG));
         chk(req, "done pulse", int'(wr_done_o), 1);
         @(negedge clk);
         chk(req, "done width", int'(wr_done_o), 0);
      end else begin
         repeat (3) begin
            chk(req, "no program wip", int'(wip_o), 0);
            chk(req, "no done pulse", int'(wr_done_o), 0);
            @(negedge clk);
         end
      end
   endtask

   task automatic read_chk(int addr, string req);
      rd_en_i   = 1'b1;
      rd_addr_i = AW'(addr);
      @(negedge clk);
      rd_en_i   = 1'b0;
      chk(req, "read valid", int'(rd_valid_o), 1);
      chk(req, $sformatf("data at %0h", addr), int'(rd_data_o), int'(mdl[addr]));
   endtask

   task automatic check_page(int pg, string req);
      for (int i = 0; i < int'(PAGE); i++) read_chk(pg * int'(PAGE) + i, req);
   endtask

   // Builds the expected page from the requirements: offsets wrap, last byte wins
   task automatic write_cmd(int addr, int n, int seed, logic [31:0] prot,
                            bit wel, bit al, string req);
      logic [7:0] sb [PAGE];
      bit         sm [PAGE];
      bit         run;
      int         off;
      logic [7:0] d;
      for (int o = 0; o < int'(PAGE); o++) begin
         sb[o] = '0;
         sm[o] = 1'b0;
      end
      send_cmd(addr, wel);
      for (int k = 0; k < n; k++) begin
         off = (addr + k) % int'(PAGE);
         d   = 8'((seed + k * 11) & 255);
         send_byte(d, prot[off]);
         sb[off] = d;
         sm[off] = !prot[off];
      end
      send_desel(al);
      run = wel && al && (n > 0);
      wait_prog(req, run);
      if (run) begin
         for (int o = 0; o < int'(PAGE); o++) begin
            if (sm[o]) mdl[(addr / int'(PAGE)) * int'(PAGE) + o] = sb[o];
         end
      end
      check_page(addr / int'(PAGE), req);
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R7 watchdog: actual hung expected finish");
         report();
         $finish;
      end
   end

   initial begin
      int n;
      for (int i = 0; i < int'(MEM); i++) mdl[i] = 8'hFF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: idle outputs and erased array
      chk("R1", "wip after reset", int'(wip_o), 0);
      chk("R1", "done after reset", int'(wr_done_o), 0);
      for (int pg = 0; pg < int'(MEM / PAGE); pg++) check_page(pg, "R1 R10");

      // R2 R3 R7: every start offset, bursts from 1 to 45 bytes
      for (int s = 0; s < int'(PAGE); s++) begin
         write_cmd((s % 4) * int'(PAGE) + s, 1 + (s * 11) % 45, s * 37 + 3, 32'h0,
                   1'b1, 1'b1, "R2 R3 R7");
      end

      // R3: short burst crossing the page end
      write_cmd(2 * int'(PAGE) + 30, 5, 8'h50, 32'h0, 1'b1, 1'b1, "R3");

      // R4: deselect off a byte boundary
      write_cmd(1 * int'(PAGE) + 5, 3, 8'h11, 32'h0, 1'b1, 1'b0, "R4");

      // R5: write-enable latch clear
      write_cmd(1 * int'(PAGE) + 5, 3, 8'h22, 32'h0, 1'b0, 1'b1, "R5");

      // R11: no data bytes
      write_cmd(3 * int'(PAGE) + 7, 0, 8'h33, 32'h0, 1'b1, 1'b1, "R11");

      // R6: protected offsets skipped, others programmed
      write_cmd(0, 32, 8'h21, 32'h0000_F0F0, 1'b1, 1'b1, "R6");

      // R9: stale buffer bytes from a cancelled command must not be written
      write_cmd(3 * int'(PAGE), 4, 8'h40, 32'h0, 1'b1, 1'b1, "R9");
      write_cmd(3 * int'(PAGE), 4, 8'hC0, 32'h0, 1'b1, 1'b0, "R9");
      write_cmd(3 * int'(PAGE) + 2, 1, 8'h99, 32'h0, 1'b1, 1'b1, "R9");

      // R9: bytes outside any command are ignored
      send_byte(8'h77, 1'b0);
      send_desel(1'b1);
      wait_prog("R9", 1'b0);
      check_page(3, "R9");

      // R8: a full command and a read inside a busy cycle
      send_cmd(2 * int'(PAGE) + 10, 1'b1);
      send_byte(8'hA1, 1'b0);
      send_byte(8'hA2, 1'b0);
      send_desel(1'b1);
      chk("R8", "wip after deselect", int'(wip_o), 1);
      n = 1;
      cmd_start_i = 1'b1;
      addr_i      = AW'(20);
      wel_i       = 1'b1;
      @(negedge clk);
      n += int'(wip_o);
      cmd_start_i = 1'b0;
      repeat (3) begin
         byte_valid_i = 1'b1;
         byte_i       = 8'h5A;
         @(negedge clk);
         n += int'(wip_o);
         byte_valid_i = 1'b0;
      end
      desel_i        = 1'b1;
      byte_aligned_i = 1'b1;
      @(negedge clk);
      n += int'(wip_o);
      desel_i        = 1'b0;
      byte_aligned_i = 1'b0;
      rd_en_i   = 1'b1;
      rd_addr_i = AW'(2 * PAGE + 10);
      @(negedge clk);
      n += int'(wip_o);
      rd_en_i = 1'b0;
      chk("R8", "read while busy", int'(rd_valid_o), 0);
      while (wip_o) begin
         @(negedge clk);
         if (wip_o) n++;
      end
      chk("R8", "program length with traffic", n, int'(PROG));
      chk("R8", "done pulse", int'(wr_done_o), 1);
      @(negedge clk);
      chk("R8", "second command did not start", int'(wip_o), 0);
      mdl[2 * PAGE + 10] = 8'hA1;
      mdl[2 * PAGE + 11] = 8'hA2;
      check_page(2, "R8");
      check_page(0, "R8");

      finished = 1'b1;
      report();
      $finish;
   end

endmodule